// File: doc/BRIEF.md
# PWM Pair Brake Controller

This block sits between a PWM waveform generator and the output pins. When a fault occurs, it drives complementary channel pairs to a safe state that software has chosen. The block takes one brake source, which has already been filtered and whose polarity has been corrected (active high). The same source goes to every channel pair. Each pair has two detectors, and each is enabled on its own. The edge detector reacts to a low-to-high transition of the source. Its brake is latched: it stays in force until software clears the pair's edge flag and a new PWM period has then started. The level detector reacts while the source is high. It lets go by itself at the first period start at which the source is low, even if its flag is still set.

The safe action is chosen per pair and separately for the even and the odd channel. When a brake is detected, the override applies in the same clock cycle. Each pair has an edge status flag and a level status flag. These flags are write-one-to-clear, and a single interrupt is the OR of every set flag whose enable is on.

Top module: `pwm_pair_brake`

## Requirements
- R1: After reset, all status flags and the interrupt are 0, and every channel output equals its PWM input with its output enable at 1.
- R2: A 0-to-1 transition of the brake source while a pair's edge enable is 1 overrides that pair's outputs in the same cycle. The pair's edge flag reads 1 from the next cycle.
- R3: With a pair's edge and level enables at 0, a brake source transition sets no flag for that pair and its outputs keep following the PWM inputs.
- R4: The action fields are 2 bits per channel: 00 pass the PWM input, 01 output enable 0 with value 0, 10 drive 0, 11 drive 1. The even and odd channels of a pair each obey their own field.
- R5: A latched edge brake stays in force across period starts while its flag is set. Once the flag reads 0, the first period start releases it, and the outputs follow the PWM from the next cycle.
- R6: A brake source at 1 while a pair's level enable is 1 overrides that pair's outputs in the same cycle. The pair's level flag reads 1 from the next cycle.
- R7: A level brake is released by a period start during which the source is 0, with effect from the next cycle, whatever the state of its flag.
- R8: A period start while the source is still 1 does not release a level brake.
- R9: A clear strobe sets the addressed flag to 0 in the next cycle. If a new detection happens in the same cycle, the flag stays at 1.
- R10: The interrupt is 1 exactly when some flag is set and its own enable is 1. Dropping the enable masks it without clearing the flag.
- R11: A pair whose enables are 0 is unaffected by brakes taken by other pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_even_i | input | NP | Normal waveform, even channel of each pair |
| pwm_odd_i | input | NP | Normal waveform, odd channel of each pair |
| period_start_i | input | NP | One-cycle pulse at the start of each pair's PWM period |
| brake_src_i | input | 1 | Filtered brake source, active high |
| edge_ien_i | input | NP | Per-pair edge detector enable |
| level_ien_i | input | NP | Per-pair level detector enable |
| act_even_i | input | 2*NP | Even-channel action, 2 bits per pair |
| act_odd_i | input | 2*NP | Odd-channel action, 2 bits per pair |
| edge_clr_i | input | NP | Write-one-to-clear strobe for edge flags |
| level_clr_i | input | NP | Write-one-to-clear strobe for level flags |
| ch_even_o | output | NP | Even channel output value |
| ch_odd_o | output | NP | Odd channel output value |
| ch_even_oe_o | output | NP | Even channel output enable |
| ch_odd_oe_o | output | NP | Odd channel output enable |
| edge_sts_o | output | NP | Edge brake status flags |
| level_sts_o | output | NP | Level brake status flags |
| brake_irq_o | output | 1 | Shared brake interrupt |

## Verification
Two things can land in the same cycle: a software clear strobe for a flag and a fresh detection on that same flag. To provoke this, the bench first latches an edge brake and lets the source fall. It then raises the source again in the very cycle that carries the edge clear strobe, and requires the flag to read 1 afterwards. The release rules are also tested against period-start timing. The bench checks that a period start does not release an edge brake while its flag is set. It also checks that a period start during a high source does not release a level brake, and that outputs return to normal exactly one cycle after a qualifying period start.

// File: rtl/pwm_brk_pkg.sv
// Shared types for the PWM pair brake controller.
// Assumes: 2-bit action fields per channel.
package pwm_brk_pkg;
    typedef enum logic [1:0] {
        ACT_PASS = 2'b00,
        ACT_HIZ  = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } brk_act_e;
endpackage

// File: rtl/brk_edge_path.sv
// Latched edge brake path, one slice per channel pair.
// Assumes: src_rise_i is a single-cycle rising-edge strobe of the brake source.
// A brake holds until its flag is cleared and then a period start arrives.
module brk_edge_path #(
    parameter int NP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_rise_i,
    input  logic [NP-1:0] ien_i,
    input  logic [NP-1:0] clr_i,
    input  logic [NP-1:0] period_start_i,
    output logic [NP-1:0] sts_o,
    output logic [NP-1:0] force_o
);
    logic [NP-1:0] hold_q;
    logic [NP-1:0] sts_q;

    for (genvar p = 0; p < NP; p++) begin : g_pair
        logic hit;
        assign hit = src_rise_i & ien_i[p];

        // Status flag: detection wins over the clear strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)          sts_q[p] <= 1'b0;
            else if (hit)        sts_q[p] <= 1'b1;
            else if (clr_i[p])   sts_q[p] <= 1'b0;
        end

        // Brake state: released at a period start once the flag reads clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 hold_q[p] <= 1'b0;
            else if (hit)                               hold_q[p] <= 1'b1;
            else if (period_start_i[p] && !sts_q[p])    hold_q[p] <= 1'b0;
        end

        assign force_o[p] = hold_q[p] | hit;
    end

    assign sts_o = sts_q;
endmodule

// File: rtl/brk_level_path.sv
// Self-releasing level brake path, one slice per channel pair.
// Assumes: src_i is the filtered active-high brake source.
// A brake ends at a period start seen while the source is low.
module brk_level_path #(
    parameter int NP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_i,
    input  logic [NP-1:0] ien_i,
    input  logic [NP-1:0] clr_i,
    input  logic [NP-1:0] period_start_i,
    output logic [NP-1:0] sts_o,
    output logic [NP-1:0] force_o
);
    logic [NP-1:0] hold_q;
    logic [NP-1:0] sts_q;

    for (genvar p = 0; p < NP; p++) begin : g_pair
        logic hit;
        assign hit = src_i & ien_i[p];

        // Status flag: detection wins over the clear strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)          sts_q[p] <= 1'b0;
            else if (hit)        sts_q[p] <= 1'b1;
            else if (clr_i[p])   sts_q[p] <= 1'b0;
        end

        // Brake state: independent of the flag, ends on a quiet period start.
        always_ff @(posedge clk) begin
            if (!rst_n)                               hold_q[p] <= 1'b0;
            else if (hit)                             hold_q[p] <= 1'b1;
            else if (period_start_i[p] && !src_i)     hold_q[p] <= 1'b0;
        end

        assign force_o[p] = hold_q[p] | hit;
    end

    assign sts_o = sts_q;
endmodule

// File: rtl/brk_out_mux.sv
// Output override for each channel pair: applies the even/odd actions
// while the pair is braked, otherwise passes the PWM waveforms.
// Assumes: purely combinational; the caller supplies the force per pair.
module brk_out_mux
    import pwm_brk_pkg::*;
#(
    parameter int NP    = 3,
    parameter int ACT_W = 2
) (
    input  logic [NP-1:0]       force_i,
    input  logic [NP*ACT_W-1:0] act_even_i,
    input  logic [NP*ACT_W-1:0] act_odd_i,
    input  logic [NP-1:0]       pwm_even_i,
    input  logic [NP-1:0]       pwm_odd_i,
    output logic [NP-1:0]       even_o,
    output logic [NP-1:0]       odd_o,
    output logic [NP-1:0]       even_oe_o,
    output logic [NP-1:0]       odd_oe_o
);
    // Returns {enable, value} for one channel.
    function automatic logic [1:0] apply(input logic brk, input logic [ACT_W-1:0] act,
                                         input logic pwm);
        if (!brk) return {1'b1, pwm};
        case (brk_act_e'(act))
            ACT_HIZ:  return 2'b00;
            ACT_LOW:  return 2'b10;
            ACT_HIGH: return 2'b11;
            default:  return {1'b1, pwm};
        endcase
    endfunction

    for (genvar p = 0; p < NP; p++) begin : g_pair
        // Per-channel selection of the safe state.
        always_comb begin
            {even_oe_o[p], even_o[p]} = apply(force_i[p], act_even_i[p*ACT_W +: ACT_W],
                                              pwm_even_i[p]);
            {odd_oe_o[p], odd_o[p]}   = apply(force_i[p], act_odd_i[p*ACT_W +: ACT_W],
                                              pwm_odd_i[p]);
        end
    end
endmodule

// File: rtl/pwm_pair_brake.sv
// Top of the PWM pair brake controller. Derives the source rising edge,
// runs the edge and level paths, overrides outputs and forms the interrupt.
// Assumes: brake source is low while reset is released (edge register resets to 0).
module pwm_pair_brake #(
    parameter int NP    = 3,
    parameter int ACT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NP-1:0]     pwm_even_i,
    input  logic [NP-1:0]     pwm_odd_i,
    input  logic [NP-1:0]     period_start_i,
    input  logic              brake_src_i,
    input  logic [NP-1:0]     edge_ien_i,
    input  logic [NP-1:0]     level_ien_i,
    input  logic [NP*ACT_W-1:0] act_even_i,
    input  logic [NP*ACT_W-1:0] act_odd_i,
    input  logic [NP-1:0]     edge_clr_i,
    input  logic [NP-1:0]     level_clr_i,
    output logic [NP-1:0]     ch_even_o,
    output logic [NP-1:0]     ch_odd_o,
    output logic [NP-1:0]     ch_even_oe_o,
    output logic [NP-1:0]     ch_odd_oe_o,
    output logic [NP-1:0]     edge_sts_o,
    output logic [NP-1:0]     level_sts_o,
    output logic              brake_irq_o
);
    logic          src_q;
    logic          src_rise;
    logic [NP-1:0] edge_force;
    logic [NP-1:0] level_force;

    // Previous source sample for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= brake_src_i;
    end

    assign src_rise = brake_src_i & ~src_q;

    brk_edge_path #(.NP(NP)) u_edge (
        .clk            (clk),
        .rst_n          (rst_n),
        .src_rise_i     (src_rise),
        .ien_i          (edge_ien_i),
        .clr_i          (edge_clr_i),
        .period_start_i (period_start_i),
        .sts_o          (edge_sts_o),
        .force_o        (edge_force)
    );

    brk_level_path #(.NP(NP)) u_level (
        .clk            (clk),
        .rst_n          (rst_n),
        .src_i          (brake_src_i),
        .ien_i          (level_ien_i),
        .clr_i          (level_clr_i),
        .period_start_i (period_start_i),
        .sts_o          (level_sts_o),
        .force_o        (level_force)
    );

    brk_out_mux #(.NP(NP), .ACT_W(ACT_W)) u_mux (
        .force_i    (edge_force | level_force),
        .act_even_i (act_even_i),
        .act_odd_i  (act_odd_i),
        .pwm_even_i (pwm_even_i),
        .pwm_odd_i  (pwm_odd_i),
        .even_o     (ch_even_o),
        .odd_o      (ch_odd_o),
        .even_oe_o  (ch_even_oe_o),
        .odd_oe_o   (ch_odd_oe_o)
    );

    // Shared interrupt: any set flag whose enable is on.
    assign brake_irq_o = |((edge_sts_o & edge_ien_i) | (level_sts_o & level_ien_i));
endmodule

// File: rtl/pwm_pair_brake_chk.sv
// Assertion checker for pwm_pair_brake, attached by bind.
module pwm_pair_brake_chk #(
    parameter int NP    = 3,
    parameter int ACT_W = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                brake_src_i,
    input logic [NP-1:0]       edge_ien_i,
    input logic [NP-1:0]       level_ien_i,
    input logic [NP*ACT_W-1:0] act_even_i,
    input logic [NP-1:0]       edge_clr_i,
    input logic [NP-1:0]       ch_even_o,
    input logic [NP-1:0]       ch_even_oe_o,
    input logic [NP-1:0]       edge_sts_o,
    input logic [NP-1:0]       level_sts_o,
    input logic                brake_irq_o
);
    for (genvar p = 0; p < NP; p++) begin : g_pair
        // R2: an edge flag only rises after the source was high with the enable on.
        p_edge_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(edge_sts_o[p]) |-> ($past(brake_src_i) && $past(edge_ien_i[p])));

        // R5: while the edge flag is set, a drive-low even action is in force.
        p_edge_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_sts_o[p] && act_even_i[p*ACT_W +: ACT_W] == 2'b10)
            |-> (!ch_even_o[p] && ch_even_oe_o[p]));

        // R6: a high source with the level enable applies drive-high at once.
        p_level_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (brake_src_i && level_ien_i[p] && act_even_i[p*ACT_W +: ACT_W] == 2'b11)
            |-> (ch_even_o[p] && ch_even_oe_o[p]));

        // R9: a clear with no detection empties the edge flag.
        p_edge_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_clr_i[p] && !brake_src_i) |=> !edge_sts_o[p]);
    end

    // R10: no flag set means no interrupt.
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sts_o == '0 && level_sts_o == '0) |-> !brake_irq_o);
endmodule

bind pwm_pair_brake pwm_pair_brake_chk #(.NP(NP), .ACT_W(ACT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .brake_src_i  (brake_src_i),
    .edge_ien_i   (edge_ien_i),
    .level_ien_i  (level_ien_i),
    .act_even_i   (act_even_i),
    .edge_clr_i   (edge_clr_i),
    .ch_even_o    (ch_even_o),
    .ch_even_oe_o (ch_even_oe_o),
    .edge_sts_o   (edge_sts_o),
    .level_sts_o  (level_sts_o),
    .brake_irq_o  (brake_irq_o)
);

// File: tb/tb_pwm_pair_brake.sv
// Directed bench for pwm_pair_brake: one task per scenario.
module tb_pwm_pair_brake;
    localparam int NP     = 3;
    localparam int ACT_W  = 2;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NP-1:0]     pwm_even, pwm_odd, period_start;
    logic              brake_src;
    logic [NP-1:0]     edge_ien, level_ien, edge_clr, level_clr;
    logic [NP*ACT_W-1:0] act_even, act_odd;
    logic [NP-1:0]     ch_even, ch_odd, ch_even_oe, ch_odd_oe, edge_sts, level_sts;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_pair_brake #(.NP(NP), .ACT_W(ACT_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .pwm_even_i(pwm_even), .pwm_odd_i(pwm_odd), .period_start_i(period_start),
        .brake_src_i(brake_src), .edge_ien_i(edge_ien), .level_ien_i(level_ien),
        .act_even_i(act_even), .act_odd_i(act_odd),
        .edge_clr_i(edge_clr), .level_clr_i(level_clr),
        .ch_even_o(ch_even), .ch_odd_o(ch_odd),
        .ch_even_oe_o(ch_even_oe), .ch_odd_oe_o(ch_odd_oe),
        .edge_sts_o(edge_sts), .level_sts_o(level_sts), .brake_irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected {oe, value} for one channel from the action encoding.
    function automatic logic [1:0] model(input logic brk, input logic [1:0] act, input logic pwm);
        if (!brk) return {1'b1, pwm};
        case (act)
            2'b01:   return 2'b00;
            2'b10:   return 2'b10;
            2'b11:   return 2'b11;
            default: return {1'b1, pwm};
        endcase
    endfunction

    // Compare one pair's four output bits against the model.
    task automatic chk_pair(input string tag, input int p, input logic brk);
        logic [1:0] e, o;
        e = model(brk, act_even[p*ACT_W +: ACT_W], pwm_even[p]);
        o = model(brk, act_odd[p*ACT_W +: ACT_W], pwm_odd[p]);
        chk(tag, {28'd0, ch_even_oe[p], ch_even[p], ch_odd_oe[p], ch_odd[p]},
            {28'd0, e, o});
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_period();
        period_start = '1;
        tick();
        period_start = '0;
        #1;
    endtask

    task automatic cleanup();
        brake_src = 1'b0; edge_ien = '0; level_ien = '0;
        tick();
        edge_clr = '1; level_clr = '1;
        tick();
        edge_clr = '0; level_clr = '0;
        pulse_period();
    endtask

    task automatic t_reset();
        chk("R1 edge flags", {29'd0, edge_sts}, 32'd0);
        chk("R1 level flags", {29'd0, level_sts}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        for (int p = 0; p < NP; p++) chk_pair("R1 outputs", p, 1'b0);
    endtask

    task automatic t_edge_latch();
        edge_ien = 3'b001;
        act_even = 6'b00_00_10; act_odd = 6'b00_00_11;
        act_even[3:2] = 2'b10;  act_odd[3:2] = 2'b11;
        pwm_even = 3'b011; pwm_odd = 3'b001;
        brake_src = 1'b1; #1;
        chk_pair("R2 same-cycle force", 0, 1'b1);
        chk_pair("R11 pair1 untouched", 1, 1'b0);
        tick();
        chk("R2 edge flag", {29'd0, edge_sts}, 32'd1);
        chk("R10 irq on", {31'd0, irq}, 32'd1);
        brake_src = 1'b0; pwm_even = 3'b100;
        tick();
        pulse_period();
        chk_pair("R5 held over period start", 0, 1'b1);
        edge_clr = 3'b001;
        tick();
        edge_clr = '0; #1;
        chk("R9 flag cleared", {29'd0, edge_sts}, 32'd0);
        chk("R10 irq off", {31'd0, irq}, 32'd0);
        chk_pair("R5 held after clear", 0, 1'b1);
        pulse_period();
        chk_pair("R5 released", 0, 1'b0);
        cleanup();
    endtask

    task automatic t_edge_off();
        pwm_even = 3'b111; pwm_odd = 3'b000;
        act_even = 6'b10_10_10; act_odd = 6'b11_11_11;
        brake_src = 1'b1; #1;
        for (int p = 0; p < NP; p++) chk_pair("R3 no enable pass", p, 1'b0);
        tick();
        chk("R3 no flag", {26'd0, edge_sts, level_sts}, 32'd0);
        cleanup();
    endtask

    task automatic t_actions();
        level_ien = 3'b100;
        pwm_even = 3'b100; pwm_odd = 3'b000;
        brake_src = 1'b1;
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                act_even[5:4] = 2'(a);
                act_odd[5:4]  = 2'(b);
                #1;
                chk_pair("R4 action code", 2, 1'b1);
            end
        end
        cleanup();
    endtask

    task automatic t_level();
        level_ien = 3'b010;
        act_even = 6'b00_11_00; act_odd = 6'b00_01_00;
        pwm_even = 3'b000; pwm_odd = 3'b010;
        brake_src = 1'b1; #1;
        chk_pair("R6 same-cycle force", 1, 1'b1);
        tick();
        chk("R6 level flag", {29'd0, level_sts}, 32'd2);
        pulse_period();
        chk_pair("R8 held while source high", 1, 1'b1);
        brake_src = 1'b0; #1;
        chk_pair("R7 held until period start", 1, 1'b1);
        tick();
        pulse_period();
        chk_pair("R7 auto release", 1, 1'b0);
        chk("R7 flag still set", {29'd0, level_sts}, 32'd2);
        chk("R10 irq pending", {31'd0, irq}, 32'd1);
        level_ien = '0; #1;
        chk("R10 irq masked", {31'd0, irq}, 32'd0);
        chk("R10 flag kept", {29'd0, level_sts}, 32'd2);
        cleanup();
    endtask

    task automatic t_collision();
        edge_ien = 3'b001;
        brake_src = 1'b1;
        tick();
        brake_src = 1'b0;
        tick();
        brake_src = 1'b1; edge_clr = 3'b001;
        tick();
        edge_clr = '0; #1;
        chk("R9 set wins over clear", {29'd0, edge_sts}, 32'd1);
        cleanup();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pwm_even = '0; pwm_odd = '0; period_start = '0;
        brake_src = 1'b0; edge_ien = '0; level_ien = '0;
        edge_clr = '0; level_clr = '0; act_even = '0; act_odd = '0;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        pwm_even = 3'b101; pwm_odd = 3'b010;
        act_even = 6'b11_10_01; act_odd = 6'b10_11_10;
        tick();
        t_reset();
        t_edge_latch();
        t_edge_off();
        t_actions();
        t_level();
        t_collision();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule